// File: doc/BRIEF.md
# Kernel Launch Register Window

This block sits on a host-facing memory-mapped port and lets software prepare a compute-kernel descriptor, one field at a time, and then start it. The window is a 4096-byte range at a configurable base. Its first eight bytes form a control word. Any store there starts a launch, and an 8-byte load there returns whether any kernel has ever been started. The bytes above the control word are a staging copy of the descriptor. Software writes them with 1, 2, 4 or 8-byte stores and can read them back.

When a launch is accepted, the block turns the staged sizes into a three-dimensional workgroup grid. Each dimension's count is the global size divided by the workgroup size, rounded up, and the total is the product of the three counts. The block tags the result with the next sequential kernel number and places the record in a small in-order queue toward the workgroup dispatcher. Every accepted access gets one response a fixed number of cycles later. Malformed or out-of-range accesses are answered with an error and change nothing. While the queue is full, a launch store is held off by the ready signal.

Top module: `kernel_launch_regs`

## Requirements
- R1: An access whose address lies below BASE_ADDR or at or above BASE_ADDR+4096 is answered with an error and changes neither the descriptor nor the launch queue.
- R2: Only byte counts 1, 2, 4 and 8 on `req_size` are legal. Any other count is answered with an error and has no effect.
- R3: Window offset 0 is the control word. An 8-byte read there returns the started flag in bit 0, with bits 63:1 zero. A read there of any other size, and any access at offsets 1 to 7, is answered with an error.
- R4: A write at window offset N (N at least 8) stores data byte k into descriptor byte N-8+k, little-endian. A read at the same offset returns those bytes, with the bytes above the access size zero. An access with N-8+size greater than DESC_BYTES is answered with an error and has no effect.
- R5: A legal-size write at offset 0 launches. The launch record carries a kernel number that is 0 after reset and increases by one per launch.
- R6: The descriptor holds three 32-bit global sizes x, y, z at descriptor bytes 0, 4, 8 and three 16-bit workgroup sizes x, y, z at bytes 12, 14, 16. Each count is ceil(global/workgroup). A workgroup size of 0 gives a count of 0. The total is the 96-bit product of the three counts.
- R7: The started flag is 0 after reset, becomes 1 with the first launch and stays 1 until reset.
- R8: While QDEPTH records are queued, `req_ready` is low for a launch write until a record is popped. Every other access is still accepted.
- R9: Each accepted access (req_valid and req_ready at a clock edge) produces exactly one single-cycle `rsp_valid`, RSP_LAT cycles later. An error response carries zero data, and so does a write response.
- R10: `lq_valid` is high while the queue holds a record, and the outputs show the oldest record. That record is removed at a clock edge where `lq_ready` is high, so records leave in launch order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Byte count of the access |
| req_wdata | input | 64 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 64 | Read data |
| lq_valid | output | 1 | Launch record available |
| lq_ready | input | 1 | Downstream takes the record |
| lq_id | output | ID_W | Kernel number |
| lq_ngrp_x | output | 32 | Workgroup count, x |
| lq_ngrp_y | output | 32 | Workgroup count, y |
| lq_ngrp_z | output | 32 | Workgroup count, z |
| lq_total | output | 96 | Product of the three counts |

## Verification
A corrupted staging byte shows up on the next readback at that offset, and also in the grid counts of the next launch record. Either appears within RSP_LAT cycles of the read, or as soon as the record reaches the queue head. A miscounted queue shows up as a wrong `req_ready` on the fifth queued launch, or as a missing or extra record when the queue drains. A wrong kernel counter shows up as a gap in the numbers popped in order. Errors at the edge cases (offsets 1 to 7, partial control reads, descriptor overrun, out-of-window addresses that would alias if truncated) are each followed by a readback that proves nothing was written.

// File: rtl/klr_pkg.sv
`timescale 1ns/100ps
package klr_pkg;

    localparam int CNT_W = 32;
    localparam int TOT_W = 3 * CNT_W;
    localparam int GRID_BITS = 144;  // descriptor bytes 0..17

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [63:0] data;
    } rsp_t;

    typedef struct packed {
        logic [CNT_W-1:0] cx;
        logic [CNT_W-1:0] cy;
        logic [CNT_W-1:0] cz;
        logic [TOT_W-1:0] total;
    } grid_t;

    // Rounded-up quotient without forming g+w-1, so no overflow.
    function automatic logic [CNT_W-1:0] ceil_div(input logic [31:0] g, input logic [15:0] w);
        logic [31:0] q;
        logic [31:0] r;
        if (w == 16'd0) return '0;
        q = g / {16'd0, w};
        r = g % {16'd0, w};
        return q + {31'd0, (r != 32'd0)};
    endfunction

    function automatic grid_t grid_of(input logic [GRID_BITS-1:0] d);
        grid_t             g;
        logic [2*CNT_W-1:0] xy;
        g.cx = ceil_div(d[31:0],  d[111:96]);
        g.cy = ceil_div(d[63:32], d[127:112]);
        g.cz = ceil_div(d[95:64], d[143:128]);
        xy = {32'd0, g.cx} * {32'd0, g.cy};
        g.total = {32'd0, xy} * {64'd0, g.cz};
        return g;
    endfunction

endpackage

// File: rtl/klr_desc_store.sv
`timescale 1ns/100ps
module klr_desc_store #(
    parameter int DESC_BYTES = 24,
    parameter int OFF_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        addr,
    input  logic [3:0]              size,
    input  logic [63:0]             wdata,
    output logic [63:0]             rdata,
    output logic [DESC_BYTES*8-1:0] flat
);
    typedef struct packed {
        logic [DESC_BYTES*8-1:0] bytes;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int b = 0; b < DESC_BYTES; b++) begin
            for (int k = 0; k < 8; k++) begin
                if (k < int'(size) && int'(addr) + k == b) begin
                    rdata[k*8 +: 8] = st_q.bytes[b*8 +: 8];
                    if (wr_en) st_d.bytes[b*8 +: 8] = wdata[k*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flat = st_q.bytes;
endmodule

// File: rtl/klr_launch_fifo.sv
`timescale 1ns/100ps
module klr_launch_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop_req,
    output logic         full,
    output logic         out_valid,
    output logic [W-1:0] dout
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t  st_d, st_q;
    logic pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        pop  = pop_req && (st_q.cnt != '0);
        if (push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = nxt(st_q.wp);
        end
        if (pop) st_d.rp = nxt(st_q.rp);
        if (push && !pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop && !push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full      = (int'(st_q.cnt) == DEPTH);
    assign out_valid = (st_q.cnt != '0);
    assign dout      = st_q.mem[st_q.rp];

    // R8: the owner must hold off launches while the queue is full
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop_req |-> !push);
endmodule

// File: rtl/klr_rsp_pipe.sv
`timescale 1ns/100ps
module klr_rsp_pipe #(
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  klr_pkg::rsp_t in,
    output klr_pkg::rsp_t out
);
    typedef struct packed {
        klr_pkg::rsp_t [LAT-1:0] stage;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.stage[0] = in;
        for (int i = 1; i < LAT; i++) st_d.stage[i] = st_q.stage[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out = st_q.stage[LAT-1];

    // R9: rejected accesses never return data
    p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out.valid && out.err |-> out.data == 64'd0);
endmodule

// File: rtl/kernel_launch_regs.sv
`timescale 1ns/100ps
module kernel_launch_regs #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] BASE_ADDR  = 32'h0001_0000,
    parameter int          WIN_BYTES  = 4096,
    parameter int          DESC_BYTES = 24,
    parameter int          QDEPTH     = 4,
    parameter int          ID_W       = 8,
    parameter int          RSP_LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              lq_valid,
    input  logic              lq_ready,
    output logic [ID_W-1:0]   lq_id,
    output logic [31:0]       lq_ngrp_x,
    output logic [31:0]       lq_ngrp_y,
    output logic [31:0]       lq_ngrp_z,
    output logic [95:0]       lq_total
);
    import klr_pkg::*;

    localparam int OFF_W = $clog2(WIN_BYTES);
    localparam int CTL_B = 8;
    localparam int REC_W = ID_W + $bits(grid_t);
    localparam logic [ADDR_W-1:0] BASE = BASE_ADDR[ADDR_W-1:0];

    typedef struct packed {
        logic            started;
        logic [ID_W-1:0] next_id;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0]       diff;
    logic [OFF_W-1:0]        off, doff;
    logic                    in_win, size_ok, is_ctl, low_bad, fits, err;
    logic                    accept, launch, dwrite, q_full, is_launch;
    logic [63:0]             desc_rd;
    logic [DESC_BYTES*8-1:0] flat;
    rsp_t                    rsp_in, rsp_out;
    grid_t                   grid;
    logic [REC_W-1:0]        rec_in, rec_out;

    always_comb begin
        diff    = req_addr - BASE;
        in_win  = (req_addr >= BASE) && (diff < ADDR_W'(WIN_BYTES));
        off     = diff[OFF_W-1:0];
        doff    = off - OFF_W'(CTL_B);
        size_ok = (req_size == 4'd1) || (req_size == 4'd2) ||
                  (req_size == 4'd4) || (req_size == 4'd8);
        is_ctl  = (off == '0);
        low_bad = !is_ctl && (int'(off) < CTL_B);
        fits    = (int'(doff) + int'(req_size)) <= DESC_BYTES;
        err     = !in_win || !size_ok || low_bad ||
                  (is_ctl && !req_write && req_size != 4'd8) ||
                  (!is_ctl && !low_bad && !fits);

        is_launch = req_write && is_ctl && !err;
        req_ready = !(is_launch && q_full);
        accept    = req_valid && req_ready;
        launch    = accept && is_launch;
        dwrite    = accept && req_write && !is_ctl && !err;

        rsp_in.valid = accept;
        rsp_in.err   = err;
        rsp_in.data  = '0;
        if (!err && !req_write)
            rsp_in.data = is_ctl ? {63'd0, st_q.started} : desc_rd;

        grid   = grid_of(flat[GRID_BITS-1:0]);
        rec_in = {st_q.next_id, grid};

        st_d = st_q;
        if (launch) begin
            st_d.started = 1'b1;
            st_d.next_id = st_q.next_id + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    klr_desc_store #(.DESC_BYTES(DESC_BYTES), .OFF_W(OFF_W)) u_desc (
        .clk(clk), .rst_n(rst_n), .wr_en(dwrite), .addr(doff),
        .size(req_size), .wdata(req_wdata), .rdata(desc_rd), .flat(flat));

    klr_launch_fifo #(.W(REC_W), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(launch), .din(rec_in),
        .pop_req(lq_ready), .full(q_full), .out_valid(lq_valid), .dout(rec_out));

    klr_rsp_pipe #(.LAT(RSP_LAT)) u_rsp (
        .clk(clk), .rst_n(rst_n), .in(rsp_in), .out(rsp_out));

    assign rsp_valid = rsp_out.valid;
    assign rsp_err   = rsp_out.err;
    assign rsp_rdata = rsp_out.data;
    assign {lq_id, lq_ngrp_x, lq_ngrp_y, lq_ngrp_z, lq_total} = rec_out;

    // R7: once started, the flag never drops
    p_started_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started |=> st_q.started);
    // R7: a launch always leaves the flag set
    p_launch_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> st_q.started);
    // R5: kernel numbers advance by exactly one per launch
    p_id_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> st_q.next_id == $past(st_q.next_id) + 1'b1);
    // R1: nothing outside the window reaches the descriptor
    p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dwrite |-> in_win && size_ok);
endmodule

// File: tb/sim_kernel_launch_regs.sv
`timescale 1ns/100ps
module sim_kernel_launch_regs;
    localparam int          LAT = 2;
    localparam logic [31:0] B   = 32'h0001_0000;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0, lq_ready = 0;
    logic [31:0] req_addr = 0;
    logic [3:0]  req_size = 0;
    logic [63:0] req_wdata = 0;
    logic        req_ready, rsp_valid, rsp_err, lq_valid;
    logic [63:0] rsp_rdata;
    logic [7:0]  lq_id;
    logic [31:0] lq_ngrp_x, lq_ngrp_y, lq_ngrp_z;
    logic [95:0] lq_total;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    kernel_launch_regs #(.BASE_ADDR(B), .RSP_LAT(LAT)) u0 (.*);

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  size;
        logic [63:0] wdata;
        logic        err;
        logic [63:0] rdata;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, B+32'd8,    4'd4, 64'h64,                  1'b0, 64'h0, 4'd4},
        '{1'b1, B+32'd12,   4'd4, 64'h0A,                  1'b0, 64'h0, 4'd4},
        '{1'b1, B+32'd16,   4'd8, 64'h0003_0010_0000_0007, 1'b0, 64'h0, 4'd4},
        '{1'b1, B+32'd24,   4'd2, 64'h0001,                1'b0, 64'h0, 4'd4},
        '{1'b0, B+32'd8,    4'd8, 64'h0,                   1'b0, 64'h0000_000A_0000_0064, 4'd4},
        '{1'b0, B+32'd20,   4'd4, 64'h0,                   1'b0, 64'h0003_0010, 4'd4},
        '{1'b0, B+32'd24,   4'd1, 64'h0,                   1'b0, 64'h01, 4'd4},
        '{1'b0, B,          4'd8, 64'h0,                   1'b0, 64'h0, 4'd7},
        '{1'b1, B+32'd8,    4'd3, 64'hFF,                  1'b1, 64'h0, 4'd2},
        '{1'b0, B+32'd8,    4'd1, 64'h0,                   1'b0, 64'h64, 4'd2},
        '{1'b1, B+32'd30,   4'd4, 64'hAAAA_AAAA,           1'b1, 64'h0, 4'd4},
        '{1'b0, B+32'd28,   4'd4, 64'h0,                   1'b0, 64'h0, 4'd4},
        '{1'b0, B+32'd4,    4'd4, 64'h0,                   1'b1, 64'h0, 4'd3},
        '{1'b0, B,          4'd4, 64'h0,                   1'b1, 64'h0, 4'd3},
        '{1'b1, B+32'd4104, 4'd4, 64'h55,                  1'b1, 64'h0, 4'd1},
        '{1'b1, B-32'd8,    4'd4, 64'h55,                  1'b1, 64'h0, 4'd1},
        '{1'b0, B+32'd8,    4'd4, 64'h0,                   1'b0, 64'h64, 4'd1},
        '{1'b1, B+32'd32,   4'd8, 64'h77,                  1'b1, 64'h0, 4'd4},
        '{1'b0, B+32'd31,   4'd1, 64'h0,                   1'b0, 64'h0, 4'd4},
        '{1'b0, B+32'd24,   4'd8, 64'h0,                   1'b0, 64'h0001, 4'd4}
    };

    // expected launch records
    logic [7:0]  e_id [8];
    logic [31:0] e_x [8], e_y [8], e_z [8];
    logic [95:0] e_t [8];
    longint unsigned gx = 100, gy = 10, gz = 7, wx = 16, wy = 3, wz = 1;
    int nlaunch = 0;

    function automatic longint unsigned cdiv(longint unsigned g, longint unsigned w);
        return (w == 0) ? 0 : (g + w - 1) / w;
    endfunction

    task automatic note_launch();
        longint unsigned x = cdiv(gx, wx), y = cdiv(gy, wy), z = cdiv(gz, wz);
        e_id[nlaunch] = 8'(nlaunch);
        e_x[nlaunch] = 32'(x); e_y[nlaunch] = 32'(y); e_z[nlaunch] = 32'(z);
        e_t[nlaunch] = 96'(x * y) * 96'(z);
        nlaunch++;
    endtask

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(bit w, logic [31:0] a, logic [3:0] s, logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        #1;
    endtask

    task automatic finish_req(output logic e, output logic [63:0] r);
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        repeat (LAT - 1) @(negedge clk);
        #1;
        chk("R9 rsp_valid", 128'(rsp_valid), 128'd1);
        e = rsp_err; r = rsp_rdata;
        @(negedge clk); #1;
        chk("R9 single-cycle rsp", 128'(rsp_valid), 128'd0);
    endtask

    task automatic access(bit w, logic [31:0] a, logic [3:0] s, logic [63:0] d,
                          output logic e, output logic [63:0] r);
        drive(w, a, s, d);
        finish_req(e, r);
    endtask

    task automatic pop_check(int k);
        @(negedge clk); #1;
        chk("R10 lq_valid", 128'(lq_valid), 128'd1);
        chk("R5 kernel id", 128'(lq_id), 128'(e_id[k]));
        chk("R6 count x", 128'(lq_ngrp_x), 128'(e_x[k]));
        chk("R6 count y", 128'(lq_ngrp_y), 128'(e_y[k]));
        chk("R6 count z", 128'(lq_ngrp_z), 128'(e_z[k]));
        chk("R6 total", 128'(lq_total), 128'(e_t[k]));
        lq_ready = 1;
        @(posedge clk);
        @(negedge clk);
        lq_ready = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic        e;
        logic [63:0] r;
        repeat (3) @(negedge clk);
        #1;
        chk("reset req_ready", 128'(req_ready), 128'd1);
        chk("reset rsp_valid", 128'(rsp_valid), 128'd0);
        chk("R10 reset lq_valid", 128'(lq_valid), 128'd0);
        rst_n = 1;

        // table walk: R1 R2 R3 R4 R7 via the vector req field
        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].wdata, e, r);
            chk($sformatf("R%0d vec%0d err", VEC[i].req, i), 128'(e), 128'(VEC[i].err));
            chk($sformatf("R%0d vec%0d data", VEC[i].req, i), 128'(r), 128'(VEC[i].rdata));
        end

        // R5 R6: launch 0 with 100/16, 10/3, 7/1
        access(1, B, 4'd8, 64'h0, e, r); note_launch();
        chk("R5 launch err", 128'(e), 128'd0);
        access(0, B, 4'd8, 64'h0, e, r);
        chk("R7 started after launch", 128'(r), 128'd1);

        // R6: workgroup size zero gives count zero
        access(1, B+32'd20, 4'd2, 64'h0, e, r); wx = 0;
        access(1, B, 4'd1, 64'h0, e, r); note_launch();

        // R6: largest global size, no overflow in rounding
        access(1, B+32'd8, 4'd4, 64'hFFFF_FFFF, e, r); gx = 64'hFFFF_FFFF;
        access(1, B+32'd20, 4'd2, 64'h2, e, r); wx = 2;
        access(1, B, 4'd4, 64'h0, e, r); note_launch();

        // R6: exact divisions
        access(1, B+32'd8, 4'd8, 64'h0000_000A_0000_0064, e, r); gx = 100; gy = 10;
        access(1, B+32'd20, 4'd4, 64'h000A_0064, e, r); wx = 100; wy = 10;
        access(1, B, 4'd2, 64'h0, e, r); note_launch();

        // R8: queue full now, reads still accepted
        access(0, B, 4'd8, 64'h0, e, r);
        chk("R8 read while full", 128'(r), 128'd1);
        // R2: bad-size control write is rejected, not a launch, not stalled
        access(1, B, 4'd3, 64'h0, e, r);
        chk("R2 bad-size launch err", 128'(e), 128'd1);

        // R8: the fifth launch waits for space
        drive(1, B, 4'd8, 64'h0);
        chk("R8 ready low when full", 128'(req_ready), 128'd0);
        @(negedge clk); #1;
        chk("R8 ready still low", 128'(req_ready), 128'd0);
        pop_check(0);
        #1;
        chk("R8 ready after pop", 128'(req_ready), 128'd1);
        finish_req(e, r); note_launch();
        chk("R8 stalled launch err", 128'(e), 128'd0);

        // R10: records leave in launch order, nothing extra
        for (int k = 1; k < 5; k++) pop_check(k);
        #1;
        chk("R10 queue drained", 128'(lq_valid), 128'd0);
        access(0, B, 4'd8, 64'h0, e, r);
        chk("R7 flag stays set", 128'(r), 128'd1);

        summary();
    end
endmodule